// File: doc/BRIEF.md
# Delta-Sigma Converter Frame Reader

This block is the host side of a three-wire serial link to a delta-sigma converter. The host owns the chip select (active low) and the serial clock. The converter drives one data line. While a conversion runs, the converter holds the data line high. It pulls the line low once it has finished and gone to sleep with its result ready.

The reader idles with chip select high and the serial clock low. At intervals it lowers chip select and waits one half clock period with the clock held low, then samples the data line. If the line is high, the reader raises chip select again before any clock edge, so the converter stays asleep. If the line is low, the reader keeps chip select low and runs exactly 32 clock periods. It samples one bit on every rising clock edge, most significant bit first. The 32nd falling edge makes the converter start its next conversion.

The reader splits the captured word into an 8-bit status field and a 24-bit result field. It presents both on a valid/ready output port. The serial clock speed, the idle gap between polls and a poll-count limit are inputs. The poll-count limit drives a sticky timeout flag.

Top module: `dsadc_reader`

## Requirements
- R1: While reset is asserted, cs_n_o is 1, sck_o is 0, m_valid is 0 and err_timeout is 0.
- R2: Every poll holds cs_n_o low with sck_o low for cfg_half_div+1 cycles and then samples sdo_i. If the sample is 1, cs_n_o returns high with no rising sck_o edge. After such a poll, cs_n_o stays high for cfg_gap+1 cycles before the next poll.
- R3: If the poll sample is 0, the reader makes exactly 32 rising sck_o edges with cs_n_o low. Each high phase and each low phase between rises lasts cfg_half_div+1 cycles.
- R4: sdo_i is captured once at each rising sck_o edge. The first captured bit becomes frame bit 31 and the last becomes bit 0. Bit 31 is the converter's end-of-conversion flag, which is 0 in a valid frame.
- R5: After the 32nd falling sck_o edge, cs_n_o stays low for cfg_half_div+1 more cycles and then goes high. sck_o is never high while cs_n_o is high.
- R6: m_status carries frame bits 31..24 and m_result carries frame bits 23..0 of the frame just read.
- R7: m_valid rises when cs_n_o rises at the end of a frame. While m_ready is 0, m_valid, m_status and m_result hold, and no poll starts (cs_n_o stays high).
- R8: err_timeout rises on the poll that brings the count of consecutive polls sampling 1 up to cfg_max_polls. It stays set until a poll samples 0, which clears both the flag and the count. A cfg_max_polls of 0 never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half_div | input | DIV_W (8) | Serial clock half period, minus one, in clk cycles |
| cfg_gap | input | GAP_W (16) | Idle cycles between polls, minus one |
| cfg_max_polls | input | POLL_W (16) | Consecutive busy polls before timeout, 0 disables |
| sck_o | output | 1 | Serial clock to the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sdo_i | input | 1 | Serial data and end-of-conversion level from the converter |
| m_valid | output | 1 | Frame result available |
| m_ready | input | 1 | Consumer accepts the frame |
| m_status | output | 8 | Top eight frame bits, end-of-conversion flag included |
| m_result | output | 24 | Lower 24 frame bits, the conversion result |
| err_timeout | output | 1 | Sticky flag for too many consecutive busy polls |

## Verification
The hardest case to reach from the ports is a conversion that never ends. Only that drives the consecutive busy-poll count up to the limit and exposes the exact poll on which the flag rises. The bench's converter model therefore has a stuck mode that keeps the data line high for as many polls as needed. The bench compares the flag with its own count after every poll, then releases the model and confirms that the first frame clears the flag. Backpressure is the other hard case. The bench withholds m_ready across a whole frame and watches that chip select stays high and the output holds. The serial clock divider and the poll gap are each swept over several values, with the expected phase widths derived from them.

// File: rtl/dsadc_reader_pkg.sv
package dsadc_reader_pkg;

  // Controller phases. The serial clock and chip select are decoded from these.
  typedef enum logic [2:0] {
    RD_IDLE   = 3'd0,  // chip select high, waiting out the poll gap
    RD_TEST   = 3'd1,  // chip select low, clock low, end-of-conversion level settling
    RD_SCK_HI = 3'd2,  // serial clock high phase
    RD_SCK_LO = 3'd3,  // serial clock low phase
    RD_DONE   = 3'd4   // chip select high, frame offered downstream
  } rd_state_e;

endpackage

// File: rtl/dsadc_phase_timer.sv
module dsadc_phase_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] reload_val,
  output logic         tick
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  // A phase loaded with value V lasts V+1 cycles and ends on the tick.
  assign tick = (cnt_q == '0);

  always_comb begin
    if (restart || tick) begin
      cnt_d = reload_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dsadc_frame_shifter.sv
module dsadc_frame_shifter #(
  parameter int FRAME_W = 32,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   bit_cnt,
  output logic               full
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sreg_q;
  logic [FRAME_W-1:0] sreg_d;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cnt_d;
  logic               reg_en;

  assign full    = (cnt_q == FULL_CNT);
  assign frame   = sreg_q;
  assign bit_cnt = cnt_q;

  // The first bit shifted in ends up at the most significant position.
  always_comb begin
    reg_en = clear | shift_en;
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (shift_en) begin
      sreg_d = {sreg_q[FRAME_W-2:0], bit_in};
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (reg_en) begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_NO_OVERSHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> !full); // R3

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/dsadc_poll_watchdog.sv
module dsadc_poll_watchdog #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         poll_busy,
  input  logic         poll_ready,
  input  logic [W-1:0] max_polls,
  output logic         timeout
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W:0]   cnt_inc;
  logic         tmo_q;
  logic         tmo_d;
  logic         reg_en;

  assign timeout = tmo_q;

  always_comb begin
    reg_en  = poll_busy | poll_ready;
    cnt_d   = cnt_q;
    tmo_d   = tmo_q;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    if (poll_ready) begin
      cnt_d = '0;
      tmo_d = 1'b0;
    end else if (poll_busy) begin
      if (!(&cnt_q)) begin
        cnt_d = cnt_inc[W-1:0];
      end
      if ((max_polls != '0) && (cnt_inc >= {1'b0, max_polls})) begin
        tmo_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (reg_en) begin
      cnt_q <= cnt_d;
      tmo_q <= tmo_d;
    end
  end

  AST_TMO_ON_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> $past(poll_busy)); // R8

  AST_TMO_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ready |=> !tmo_q); // R8

  AST_TMO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_busy && max_polls == '0 && !tmo_q) |=> !tmo_q); // R8

endmodule

// File: rtl/dsadc_reader.sv
module dsadc_reader #(
  parameter int FRAME_W = 32,
  parameter int RES_W   = 24,
  parameter int DIV_W   = 8,
  parameter int GAP_W   = 16,
  parameter int POLL_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DIV_W-1:0]         cfg_half_div,
  input  logic [GAP_W-1:0]         cfg_gap,
  input  logic [POLL_W-1:0]        cfg_max_polls,
  output logic                     sck_o,
  output logic                     cs_n_o,
  input  logic                     sdo_i,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic [FRAME_W-RES_W-1:0] m_status,
  output logic [RES_W-1:0]         m_result,
  output logic                     err_timeout
);

  import dsadc_reader_pkg::*;

  localparam int STAT_W = FRAME_W - RES_W;
  localparam int CNT_W  = $clog2(FRAME_W + 1);
  localparam int TMR_W  = (DIV_W > GAP_W) ? DIV_W : GAP_W;

  // The reset is asserted asynchronously and released on a clock edge.
  logic rst_meta_q;
  logic rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  rd_state_e          state_q;
  rd_state_e          state_d;
  logic               tick;
  logic               tmr_restart;
  logic [TMR_W-1:0]   tmr_reload;
  logic               shift_en;
  logic               frame_clear;
  logic               poll_busy;
  logic               poll_ready;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   bit_cnt;
  logic               frame_full;

  // Next-state logic. Every timed phase ends on the shared timer tick.
  always_comb begin
    state_d     = state_q;
    shift_en    = 1'b0;
    poll_busy   = 1'b0;
    poll_ready  = 1'b0;
    tmr_restart = 1'b0;
    frame_clear = 1'b0;
    unique case (state_q)
      RD_IDLE: begin
        if (tick) state_d = RD_TEST;
      end
      RD_TEST: begin
        if (tick) begin
          if (sdo_i) begin
            state_d   = RD_IDLE;
            poll_busy = 1'b1;
          end else begin
            state_d    = RD_SCK_HI;
            poll_ready = 1'b1;
            shift_en   = 1'b1;
          end
        end
      end
      RD_SCK_HI: begin
        if (tick) state_d = RD_SCK_LO;
      end
      RD_SCK_LO: begin
        if (tick) begin
          if (frame_full) begin
            state_d = RD_DONE;
          end else begin
            state_d  = RD_SCK_HI;
            shift_en = 1'b1;
          end
        end
      end
      RD_DONE: begin
        if (m_ready) begin
          state_d     = RD_IDLE;
          tmr_restart = 1'b1;
          frame_clear = 1'b1;
        end
      end
      default: state_d = RD_IDLE;
    endcase
  end

  // The reload value is picked by the phase being entered.
  always_comb begin
    if (state_d == RD_IDLE) begin
      tmr_reload = TMR_W'(cfg_gap);
    end else begin
      tmr_reload = TMR_W'(cfg_half_div);
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= RD_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  dsadc_phase_timer #(
    .W (TMR_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .restart    (tmr_restart),
    .reload_val (tmr_reload),
    .tick       (tick)
  );

  dsadc_frame_shifter #(
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clear    (frame_clear),
    .shift_en (shift_en),
    .bit_in   (sdo_i),
    .frame    (frame),
    .bit_cnt  (bit_cnt),
    .full     (frame_full)
  );

  dsadc_poll_watchdog #(
    .W (POLL_W)
  ) u_watchdog (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .poll_busy  (poll_busy),
    .poll_ready (poll_ready),
    .max_polls  (cfg_max_polls),
    .timeout    (err_timeout)
  );

  // All outputs are decoded from registered state only.
  assign sck_o    = (state_q == RD_SCK_HI);
  assign cs_n_o   = (state_q == RD_IDLE) || (state_q == RD_DONE);
  assign m_valid  = (state_q == RD_DONE);
  assign m_status = frame[FRAME_W-1 -: STAT_W];
  assign m_result = frame[RES_W-1:0];

  AST_SCK_RISE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(sck_o) |-> (!cs_n_o && $past(!cs_n_o))); // R3

  AST_CS_RISE_FRAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(cs_n_o) |-> (bit_cnt == '0 || frame_full)); // R5

  AST_VALID_FULL: assert property (@(posedge clk) disable iff (!rst_n_s)
    m_valid |-> frame_full); // R3

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_status) && $stable(m_result))); // R7

  AST_NO_POLL_PENDING: assert property (@(posedge clk) disable iff (!rst_n_s)
    (m_valid && !m_ready) |=> cs_n_o); // R7

endmodule

// File: tb/dsadc_reader_test.sv
module dsadc_reader_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_half_div = '0;
  logic [15:0] cfg_gap = '0;
  logic [15:0] cfg_max_polls = '0;
  logic        sck_o;
  logic        cs_n_o;
  logic        sdo_i;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [7:0]  m_status;
  logic [23:0] m_result;
  logic        err_timeout;

  int n_checks = 0;
  int n_fail   = 0;
  int n_done   = 0;
  int polls    = 0;

  always #5 clk = ~clk;

  dsadc_reader uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_half_div  (cfg_half_div),
    .cfg_gap       (cfg_gap),
    .cfg_max_polls (cfg_max_polls),
    .sck_o         (sck_o),
    .cs_n_o        (cs_n_o),
    .sdo_i         (sdo_i),
    .m_valid       (m_valid),
    .m_ready       (m_ready),
    .m_status      (m_status),
    .m_result      (m_result),
    .err_timeout   (err_timeout)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] gen_frame(input int k);
    logic [23:0] r;
    logic [6:0]  s;
    case (k % 4)
      0:       r = 24'h000000;
      1:       r = 24'hFFFFFF;
      2:       r = 24'hA5A5A5 ^ 24'(k * 7);
      default: r = 24'(k * 40503 + 12345);
    endcase
    s = 7'(k * 13 + 1);
    return {1'b0, s, r};
  endfunction

  // Converter model: data line high while converting, frame bits MSB first,
  // next bit after each falling clock edge, new conversion after 32 falls.
  int          conv_len = 20;
  bit          stuck = 1'b0;
  bit          busy_m = 1'b1;
  int          conv_left = 0;
  int          idx = 0;
  int          frame_no = 0;
  logic [31:0] frame_m = '0;
  logic [31:0] exp_frame = '0;
  logic        prev_sck_m = 1'b0;

  assign sdo_i = cs_n_o ? 1'b1 : (busy_m ? 1'b1 : frame_m[31 - idx]);

  always @(negedge clk) begin
    if (!rst_n) begin
      busy_m    <= 1'b1;
      conv_left <= conv_len;
      idx       <= 0;
    end else begin
      if (busy_m) begin
        if (!stuck) begin
          if (conv_left == 0) begin
            busy_m  <= 1'b0;
            frame_m <= gen_frame(frame_no);
          end else begin
            conv_left <= conv_left - 1;
          end
        end
      end else if (!cs_n_o && prev_sck_m && !sck_o) begin
        if (idx == 31) begin
          exp_frame <= frame_m;
          busy_m    <= 1'b1;
          conv_left <= conv_len;
          idx       <= 0;
          frame_no  <= frame_no + 1;
        end else begin
          idx <= idx + 1;
        end
      end
    end
    prev_sck_m <= sck_o;
  end

  // Port monitor, sampled on the falling clock edge.
  bit prev_cs = 1'b1;
  bit prev_sck = 1'b0;
  bit after_poll = 1'b0;
  int cs_lo_cnt = 0;
  int cs_hi_cnt = 0;
  int hi_cnt = 0;
  int lo_cnt = 0;
  int rises = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cs = 1'b1; prev_sck = 1'b0; after_poll = 1'b0;
      cs_lo_cnt = 0; cs_hi_cnt = 0; hi_cnt = 0; lo_cnt = 0; rises = 0; polls = 0;
    end else begin
      if (cs_n_o && sck_o)
        check(1'b0, "R5", "sck high with cs high", 1, 0);
      if (!cs_n_o && prev_cs) begin
        if (after_poll)
          check(cs_hi_cnt == int'(cfg_gap) + 1, "R2", "poll gap", cs_hi_cnt, int'(cfg_gap) + 1);
        cs_lo_cnt = 0;
        rises = 0;
      end
      if (cs_n_o && !prev_cs) begin
        if (rises == 0) begin
          check(cs_lo_cnt == int'(cfg_half_div) + 1, "R2", "busy poll width", cs_lo_cnt, int'(cfg_half_div) + 1);
          polls++;
          check(err_timeout == ((cfg_max_polls != 0) && (polls >= int'(cfg_max_polls))),
                "R8", "timeout after poll", err_timeout, (cfg_max_polls != 0) && (polls >= int'(cfg_max_polls)));
          after_poll = 1'b1;
        end else begin
          check(rises == 32, "R3", "rising edges per frame", rises, 32);
          check(lo_cnt == int'(cfg_half_div) + 1, "R5", "tail after last fall", lo_cnt, int'(cfg_half_div) + 1);
          check(m_valid == 1'b1, "R7", "valid with cs rise", m_valid, 1);
          after_poll = 1'b0;
        end
        cs_hi_cnt = 0;
      end
      if (sck_o && !prev_sck) begin
        if (rises == 0) begin
          check(cs_lo_cnt == int'(cfg_half_div) + 1, "R2", "test window before first rise", cs_lo_cnt, int'(cfg_half_div) + 1);
          polls = 0;
        end else begin
          check(lo_cnt == int'(cfg_half_div) + 1, "R3", "sck low width", lo_cnt, int'(cfg_half_div) + 1);
        end
        rises++;
        hi_cnt = 0;
      end
      if (!sck_o && prev_sck) begin
        check(hi_cnt == int'(cfg_half_div) + 1, "R3", "sck high width", hi_cnt, int'(cfg_half_div) + 1);
        lo_cnt = 0;
      end
      if (m_valid && m_ready) begin
        check(m_status == exp_frame[31:24], "R6", "status field", m_status, exp_frame[31:24]);
        check(m_result == exp_frame[23:0], "R4", "result field MSB first", m_result, exp_frame[23:0]);
        check(err_timeout == 1'b0, "R8", "timeout cleared by frame", err_timeout, 0);
        n_done++;
      end
      if (cs_n_o) cs_hi_cnt++; else cs_lo_cnt++;
      if (sck_o) hi_cnt++; else lo_cnt++;
      prev_cs = cs_n_o;
      prev_sck = sck_o;
    end
  end

  task automatic do_reset(input int d, input int g, input int mx, input int cl, input bit stk);
    @(posedge clk); #1;
    rst_n = 1'b0;
    cfg_half_div = 8'(d);
    cfg_gap = 16'(g);
    cfg_max_polls = 16'(mx);
    conv_len = cl;
    stuck = stk;
    repeat (3) @(negedge clk);
    check(cs_n_o == 1'b1, "R1", "cs in reset", cs_n_o, 1);
    check(sck_o == 1'b0, "R1", "sck in reset", sck_o, 0);
    check(m_valid == 1'b0, "R1", "valid in reset", m_valid, 0);
    check(err_timeout == 1'b0, "R1", "timeout in reset", err_timeout, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic wait_frames(input int n);
    int target = n_done + n;
    while (n_done < target) @(negedge clk);
  endtask

  task automatic stall_frame();
    logic [7:0]  st;
    logic [23:0] rs;
    @(posedge clk); #1;
    m_ready = 1'b0;
    @(negedge clk);
    while (!m_valid) @(negedge clk);
    st = m_status;
    rs = m_result;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(m_valid == 1'b1, "R7", "valid held", m_valid, 1);
      check(cs_n_o == 1'b1, "R7", "no poll while pending", cs_n_o, 1);
      check({m_status, m_result} == {st, rs}, "R7", "data stable", {m_status, m_result}, {st, rs});
    end
    @(posedge clk); #1;
    m_ready = 1'b1;
    wait_frames(1);
  endtask

  task automatic run_all();
    for (int d = 0; d < 4; d++) begin
      for (int g = 0; g < 3; g += 2) begin
        do_reset(d, g, 0, 15 + 9 * d, 1'b0);
        wait_frames(2);
        stall_frame();
        wait_frames(2);
      end
    end
    // R8: converter stuck, limit of four polls, then released
    do_reset(1, 1, 4, 10, 1'b1);
    while (polls < 7) @(negedge clk);
    stuck = 1'b0;
    wait_frames(2);
    // R8: limit of one poll
    do_reset(0, 0, 1, 10, 1'b1);
    while (polls < 3) @(negedge clk);
    stuck = 1'b0;
    wait_frames(1);
    // R8: limit of zero disables the flag
    do_reset(2, 3, 0, 10, 1'b1);
    while (polls < 6) @(negedge clk);
    stuck = 1'b0;
    wait_frames(1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule